// File: doc/BRIEF.md
# Single-Transfer Bus Manager with Error Retraction

This block is a bus manager for an AHB-Lite style interconnect. Commands arrive on a valid/ready port and wait in a small in-order queue. Each command holds an address, a read/write flag and write data. The manager turns each command into one NONSEQ single transfer. It pipelines the address phase of the next command behind the data phase of the current one. Read data is returned on a one-cycle result strobe.

If a subordinate answers with the two-cycle ERROR response, the manager pulls back the address phase it is presenting. It sees the first error cycle (HRESP high, HREADY low) at a clock edge. During the second error cycle it drives IDLE, and HADDR stays on the next command's address. The IDLE is the transfer that subordinates sample, so the command behind the failed one never reaches any subordinate. That command stays at the head of the queue.

The manager then halts. It reports the failed address and drives only IDLE until the error is acknowledged. After the acknowledge, the held command is issued again as NONSEQ, so no transfer ever overtakes a failed one.

The sequencer has three states:
- RUN: issue from the queue. RUN goes to RETRACT when the first error cycle is seen during a data phase.
- RETRACT: the second error cycle, with IDLE presented. RETRACT goes to HALT when HREADY is high.
- HALT: error reported. HALT goes back to RUN on acknowledge.

Top module: `ahbm_err_mgr`

## Requirements
- R1: A command is taken when cmd_valid and cmd_ready are both high. cmd_ready is low only when all QDEPTH queue slots are occupied. Commands are presented on the bus strictly in the order they were taken.
- R2: After reset, htrans is IDLE (2'b00), err_valid is 0, rd_valid is 0 and cmd_ready is 1.
- R3: A queued command is presented with htrans = NONSEQ (2'b10), haddr equal to its address, hwrite equal to its write flag and hsize = 3'b010 (four-byte transfers). While hready is low with hresp low, htrans and haddr stay unchanged.
- R4: The write data of an accepted write is driven on hwdata during that transfer's data phase. It stays stable while hready is low.
- R5: When a read data phase completes (hready high, hresp low), rd_valid is high for exactly the next cycle, and rd_data holds the hrdata value sampled at completion.
- R6: If hresp is high and hready is low during a data phase, the manager drives htrans = IDLE in the following cycle. In that cycle haddr stays on the address of the command that was being presented.
- R7: A command retracted under R6 is not lost. After the acknowledge it is the first command presented, again as NONSEQ.
- R8: err_valid rises in the cycle after the second error cycle, and err_addr holds the failing transfer's address. While err_valid is high, htrans stays IDLE and no queued command is presented.
- R9: err_ack while err_valid is high clears err_valid in the next cycle. err_ack while err_valid is low has no effect.
- R10: Commands taken while the error is pending are kept and issued in order, after the held command, once the error is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Queue can take a command |
| cmd_addr | input | 32 | Command byte address |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_wdata | input | 32 | Write data of the command |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| err_valid | output | 1 | Error pending, issuing halted |
| err_addr | output | 32 | Address of the failed transfer |
| err_ack | input | 1 | Acknowledge of the pending error |
| haddr | output | 32 | Bus address |
| htrans | output | 2 | Transfer type (IDLE or NONSEQ) |
| hwrite | output | 1 | Bus write flag |
| hsize | output | 3 | Transfer size |
| hwdata | output | 32 | Bus write data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | Error response |
| hrdata | input | 32 | Bus read data |

## Verification
The bench runs the command flow in four patterns:
- Zero-wait back-to-back writes and reads check ordering and read-after-write data through the pipeline.
- Two wait states per transfer expose any address or write data that moves while the bus stalls.
- An erroring write with a normal write queued directly behind it shows whether the pipelined NONSEQ is withdrawn rather than performed. Issuing again after the acknowledge shows whether the held command is kept.
- An erroring write followed by a full queue while halted separates back-pressure from the halt. A stray acknowledge with no pending error shows that the acknowledge is ignored outside the halt.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        HT_IDLE   = 2'b00,
        HT_BUSY   = 2'b01,
        HT_NONSEQ = 2'b10,
        HT_SEQ    = 2'b11
    } htrans_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef enum logic [1:0] {
        S_RUN     = 2'b00,
        S_RETRACT = 2'b01,
        S_HALT    = 2'b10
    } mgr_state_t;

endpackage

// File: rtl/ahbm_cmd_queue.sv
module ahbm_cmd_queue
    import ahbm_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  cmd_t push_cmd,
    input  logic pop,
    output cmd_t head,
    output logic head_valid,
    output logic full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    cmd_t             slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_cmd;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head       = slots[rd_ptr];
    assign head_valid = (count != '0);
    assign full       = (count == CNT_W'(DEPTH));

    // R1: the sequencer never takes a command from an empty queue
    a_r1_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R1: a push is never offered to a full queue
    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

endmodule

// File: rtl/ahbm_seq.sv
module ahbm_seq
    import ahbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_t              head,
    input  logic              head_valid,
    output logic              pop,
    input  logic              hready,
    input  logic              hresp,
    input  logic [DATA_W-1:0] hrdata,
    output logic [1:0]        htrans,
    output logic [ADDR_W-1:0] haddr,
    output logic              hwrite,
    output logic [DATA_W-1:0] hwdata,
    input  logic              err_ack,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    mgr_state_t        state_q;
    mgr_state_t        state_d;
    logic              issue;
    logic              err_first;
    logic              dp_valid;
    logic              dp_write;
    logic [ADDR_W-1:0] dp_addr;
    logic [DATA_W-1:0] dp_wdata;
    logic [ADDR_W-1:0] err_addr_q;
    logic              rd_valid_q;
    logic [DATA_W-1:0] rd_data_q;

    // first cycle of the two-cycle error response, seen on an open data phase
    assign err_first = dp_valid && hresp && !hready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:     if (err_first) state_d = S_RETRACT;
            S_RETRACT: if (hready)    state_d = S_HALT;
            S_HALT:    if (err_ack)   state_d = S_RUN;
            default:   state_d = S_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // bus and status outputs
    always_comb begin
        issue     = (state_q == S_RUN) && head_valid;
        pop       = issue && hready;
        htrans    = issue ? HT_NONSEQ : HT_IDLE;
        hwrite    = issue && head.write;
        haddr     = head.addr;
        hwdata    = dp_wdata;
        err_valid = (state_q == S_HALT);
        err_addr  = err_addr_q;
        rd_valid  = rd_valid_q;
        rd_data   = rd_data_q;
    end

    // data-phase pipeline and result capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_valid   <= 1'b0;
            dp_write   <= 1'b0;
            dp_addr    <= '0;
            dp_wdata   <= '0;
            err_addr_q <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            if (hready) begin
                dp_valid <= pop;
                if (pop) begin
                    dp_write <= head.write;
                    dp_addr  <= head.addr;
                    dp_wdata <= head.wdata;
                end
            end
            rd_valid_q <= dp_valid && !dp_write && hready && !hresp;
            if (dp_valid && !dp_write && hready && !hresp) begin
                rd_data_q <= hrdata;
            end
            if ((state_q == S_RUN) && err_first) begin
                err_addr_q <= dp_addr;
            end
        end
    end

    // R6: the address phase after a first error cycle is IDLE
    a_r6_retract: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && hresp && !hready) |=> (htrans == HT_IDLE));

    // R3: a stalled NONSEQ keeps its type, address and direction
    a_r3_hold_on_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == HT_NONSEQ && !hready && !hresp)
            |=> (htrans == HT_NONSEQ && $stable(haddr) && $stable(hwrite)));

    // R4: write data holds while the write's data phase is stalled
    a_r4_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_write && !hready) |=> $stable(hwdata));

    // R5: a read result follows only a completed OKAY data phase
    a_r5_rd_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(hready && !hresp));

    // R8: the halt begins only after the second error cycle
    a_r8_err_after_resp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_valid) |-> $past(hresp && hready));

    // R8: nothing is presented while the error is pending
    a_r8_halt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (htrans == HT_IDLE && !pop));

    // R9: acknowledge clears the pending error
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && err_ack) |=> !err_valid);

endmodule

// File: rtl/ahbm_err_mgr.sv
module ahbm_err_mgr
    import ahbm_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_write,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    input  logic              err_ack,
    output logic [ADDR_W-1:0] haddr,
    output logic [1:0]        htrans,
    output logic              hwrite,
    output logic [2:0]        hsize,
    output logic [DATA_W-1:0] hwdata,
    input  logic              hready,
    input  logic              hresp,
    input  logic [DATA_W-1:0] hrdata
);

    localparam logic [2:0] SIZE_CODE = 3'($clog2(DATA_W / 8));

    cmd_t in_cmd;
    cmd_t head;
    logic head_valid;
    logic q_full;
    logic push;
    logic pop;

    assign in_cmd    = '{addr: cmd_addr, write: cmd_write, wdata: cmd_wdata};
    assign cmd_ready = !q_full;
    assign push      = cmd_valid && !q_full;
    assign hsize     = SIZE_CODE;

    ahbm_cmd_queue #(
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_cmd   (in_cmd),
        .pop        (pop),
        .head       (head),
        .head_valid (head_valid),
        .full       (q_full)
    );

    ahbm_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .head_valid (head_valid),
        .pop        (pop),
        .hready     (hready),
        .hresp      (hresp),
        .hrdata     (hrdata),
        .htrans     (htrans),
        .haddr      (haddr),
        .hwrite     (hwrite),
        .hwdata     (hwdata),
        .err_ack    (err_ack),
        .err_valid  (err_valid),
        .err_addr   (err_addr),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data)
    );

endmodule

// File: tb/test_ahbm_err_mgr.sv
module test_ahbm_err_mgr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        err_valid;
    logic [31:0] err_addr;
    logic        err_ack = 1'b0;
    logic [31:0] haddr;
    logic [1:0]  htrans;
    logic        hwrite;
    logic [2:0]  hsize;
    logic [31:0] hwdata;
    logic        hready;
    logic        hresp;
    logic [31:0] hrdata;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    ahbm_err_mgr i_ahbm_err_mgr (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_write(cmd_write), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .err_valid(err_valid), .err_addr(err_addr), .err_ack(err_ack),
        .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize),
        .hwdata(hwdata), .hready(hready), .hresp(hresp), .hrdata(hrdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- subordinate model ----------------
    // 0 ready, 1 wait, 2 first error cycle, 3 second error cycle
    int          sb_st = 0;
    int          sb_cnt = 0;
    int          wait_cfg = 0;
    logic        dph_v = 1'b0;
    logic        dph_w = 1'b0;
    logic [31:0] dph_a = '0;
    logic [31:0] smem [16];
    logic [1:0]  l_htrans = 2'b00;
    logic [31:0] l_haddr = '0;
    logic        l_hwrite = 1'b0;
    logic [31:0] l_hwdata = '0;

    assign hready = (sb_st == 0) || (sb_st == 3);
    assign hresp  = (sb_st == 2) || (sb_st == 3);
    assign hrdata = dph_v ? smem[dph_a[5:2]] : 32'h0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sb_st <= 0;
            dph_v <= 1'b0;
        end else if (sb_st == 2) begin
            sb_st <= 3;
        end else if (sb_st == 1) begin
            if (sb_cnt <= 1) sb_st <= 0;
            sb_cnt <= sb_cnt - 1;
        end else begin
            if (dph_v && dph_w && sb_st == 0) smem[dph_a[5:2]] <= l_hwdata;
            if (l_htrans == 2'b10) begin
                dph_v <= 1'b1;
                dph_w <= l_hwrite;
                dph_a <= l_haddr;
                if (l_haddr[11:8] == 4'hE) sb_st <= 2;
                else if (wait_cfg > 0) begin
                    sb_st  <= 1;
                    sb_cnt <= wait_cfg;
                end else sb_st <= 0;
            end else begin
                dph_v <= 1'b0;
                sb_st <= 0;
            end
        end
    end

    // ---------------- scoreboard ----------------
    logic [31:0] exp_acc [$];
    logic [31:0] exp_rd [$];
    logic [31:0] ref_mem [16];
    logic [31:0] retract_addr = '0;
    bit          retract_on = 1'b0;
    int          n_retract = 0;
    bit          prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    bit          prev_err1 = 1'b0;

    task automatic send(input logic [31:0] a, input logic w, input logic [31:0] d);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_write = w;
        cmd_wdata = d;
        exp_acc.push_back(a);
        if (!w) exp_rd.push_back(ref_mem[a[5:2]]);
        else if (a[11:8] != 4'hE) ref_mem[a[5:2]] = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_acc.size() != 0 || exp_rd.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor, sampling away from the active edge
    always @(negedge clk) begin
        l_htrans = htrans;
        l_haddr  = haddr;
        l_hwrite = hwrite;
        l_hwdata = hwdata;
        if (rst_n) begin
            if (prev_wait) begin
                chk(htrans == 2'b10, "R3 NONSEQ held on wait", 32'(htrans), 32'h2);
                chk(haddr == prev_addr, "R3 haddr held on wait", haddr, prev_addr);
            end
            if (prev_err1) begin
                chk(htrans == 2'b00, "R6 IDLE after first error cycle", 32'(htrans), 32'h0);
                if (retract_on)
                    chk(haddr == retract_addr, "R6 haddr held on retraction", haddr, retract_addr);
            end
            if (hresp && !hready && retract_on) begin
                chk(htrans == 2'b10, "R6 next NONSEQ presented in first error cycle",
                    32'(htrans), 32'h2);
                n_retract++;
            end
            if (err_valid)
                chk(htrans == 2'b00, "R8 IDLE while error pending", 32'(htrans), 32'h0);
            if (hready && htrans == 2'b10) begin
                if (exp_acc.size() == 0) begin
                    chk(1'b0, "R1 unexpected transfer", haddr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] e;
                    e = exp_acc.pop_front();
                    chk(haddr == e, "R1 R7 transfer order", haddr, e);
                    chk(hsize == 3'b010, "R3 hsize", 32'(hsize), 32'h2);
                end
            end
            if (rd_valid) begin
                if (exp_rd.size() == 0) begin
                    chk(1'b0, "R5 unexpected read result", rd_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_rd.pop_front();
                    chk(rd_data == e, "R5 read data", rd_data, e);
                end
            end
            prev_wait = (htrans == 2'b10) && !hready && !hresp;
            prev_addr = haddr;
            prev_err1 = hresp && !hready;
        end
    end

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            smem[i]    = '0;
            ref_mem[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        chk(htrans == 2'b00, "R2 htrans after reset", 32'(htrans), 32'h0);
        chk(!err_valid, "R2 err_valid after reset", 32'(err_valid), 32'h0);
        chk(!rd_valid, "R2 rd_valid after reset", 32'(rd_valid), 32'h0);
        chk(cmd_ready, "R2 cmd_ready after reset", 32'(cmd_ready), 32'h1);

        // R1 R3 R4 R5: zero-wait back-to-back traffic
        wait_cfg = 0;
        send(32'h00, 1'b1, 32'h1111_0000);
        send(32'h04, 1'b1, 32'h2222_0004);
        send(32'h08, 1'b1, 32'h3333_0008);
        send(32'h04, 1'b0, 32'h0);
        send(32'h00, 1'b0, 32'h0);
        send(32'h08, 1'b0, 32'h0);
        drain();

        // R3 R4: two wait states per transfer
        wait_cfg = 2;
        send(32'h10, 1'b1, 32'hA5A5_0010);
        send(32'h10, 1'b0, 32'h0);
        send(32'h04, 1'b0, 32'h0);
        drain();

        // R6 R7 R8 R10: error with a NONSEQ pipelined behind it
        wait_cfg     = 0;
        retract_addr = 32'h20;
        retract_on   = 1'b1;
        send(32'h0E00, 1'b1, 32'hDEAD_BEEF);
        send(32'h20, 1'b1, 32'h0000_00AB);
        while (!err_valid) @(negedge clk);
        chk(err_addr == 32'h0E00, "R8 err_addr", err_addr, 32'h0E00);
        chk(n_retract == 1, "R6 one retraction observed", 32'(n_retract), 32'h1);
        retract_on = 1'b0;
        send(32'h24, 1'b1, 32'h0000_00CD);
        repeat (4) @(negedge clk);
        chk(exp_acc.size() == 2, "R8 R10 nothing issued while halted",
            32'(exp_acc.size()), 32'h2);
        chk(err_valid, "R8 error still pending", 32'(err_valid), 32'h1);
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
        chk(!err_valid, "R9 ack clears error", 32'(err_valid), 32'h0);
        send(32'h20, 1'b0, 32'h0);
        send(32'h24, 1'b0, 32'h0);
        drain();

        // R9: acknowledge with no pending error is ignored
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
        @(negedge clk);
        chk(!err_valid, "R9 stray ack leaves no error", 32'(err_valid), 32'h0);
        send(32'h30, 1'b1, 32'h7777_0030);
        send(32'h30, 1'b0, 32'h0);
        drain();
        chk(!err_valid, "R9 flow continues after stray ack", 32'(err_valid), 32'h0);

        // R1 R10: fill the queue while halted
        send(32'h0E04, 1'b1, 32'h0);
        while (!err_valid) @(negedge clk);
        chk(err_addr == 32'h0E04, "R8 err_addr second error", err_addr, 32'h0E04);
        send(32'h34, 1'b1, 32'h0000_0034);
        send(32'h38, 1'b1, 32'h0000_0038);
        send(32'h3C, 1'b1, 32'h0000_003C);
        send(32'h34, 1'b0, 32'h0);
        chk(!cmd_ready, "R1 ready low when queue full", 32'(cmd_ready), 32'h0);
        err_ack = 1'b1;
        @(negedge clk);
        err_ack = 1'b0;
        send(32'h3C, 1'b0, 32'h0);
        send(32'h38, 1'b0, 32'h0);
        drain();
        chk(exp_acc.size() == 0, "R10 all queued commands issued",
            32'(exp_acc.size()), 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule